// File: doc/BRIEF.md
# Gated PCI Interrupt Mapper

This block passes 32 level-sensitive PCI interrupt lines through to 32 interrupt outputs. Eight mapping registers decide which lines get through, and each register covers a group of four consecutive lines. Input line n belongs to register n>>2. While a register's enable bit is set, its four outputs copy the input levels one clock later. While the bit is clear, those four outputs are held low.

Software reaches the registers over a simple 32-bit register port. The port decodes a 64-byte window whose base address is a parameter. Each register takes an 8-byte slot and is visible only in the upper word of that slot. The enable bit (bit 31) is the only field software can change. Bits 30:0 receive an identifying pattern at power-on and are read-only from then on.

Two resets are kept apart. Power-on loads every field. A later device reset clears only the enable bits and the outputs, and leaves bits 30:0 as they are.

Top module: `pci_irq_gate`

## Requirements
- R1: After power-on (por_n low), register i reads as (0x1F << 6) | (i << 2) with bit 31 (enable) clear, and every irq_out bit is 0.
- R2: A write with address bit 2 set, inside the window, copies wr_data bit 31 into the enable bit of register addr[5:3] at the clock edge; bits 30:0 of that register do not change, whatever wr_data holds.
- R3: A write with address bit 2 clear has no effect on any register.
- R4: A read returns the register at index addr[5:3] on the same cycle when address bit 2 is set; it returns 0 when address bit 2 is clear.
- R5: An address whose bits above bit 5 differ from the window base (default 0x0C00) is ignored on write and reads as 0.
- R6: While rst_n is low at a clock edge, all eight enable bits and all irq_out bits clear and bits 30:0 keep their value; this reset wins over a write in the same cycle.
- R7: While the governing register's enable bit is set, irq_out[n] equals irq_in[n] sampled at the previous clock edge.
- R8: While the governing register's enable bit is clear, irq_out[n] is 0 after the next clock edge, whatever irq_in[n] is.
- R9: A change of an enable bit takes effect on its four outputs at the clock edge after the write, even when the inputs hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on initialization, active low |
| rst_n | input | 1 | Synchronous device reset, active low; clears the enable bits only |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 16 | Byte address shared by reads and writes |
| wr_data | input | 32 | Write data; only bit 31 is used |
| rd_data | output | 32 | Read data, combinational from addr |
| irq_in | input | 32 | Level-sensitive PCI interrupt inputs |
| irq_out | output | 32 | Gated interrupt outputs, registered |

## Verification
Three things can happen on the same edge: a device reset, an enable write, and a change on the interrupt inputs. The random loop asserts the reset about once in forty cycles while writes and input changes continue. This makes a reset coinciding with an enabling write happen many times, and one directed case forces it. The bench model lets the reset win at that edge. It predicts cleared enables and zero outputs at the next negative edge, and it checks the read-back so that an enable which slipped through would show up.

// File: rtl/pci_irq_gate.sv
module pci_irq_gate #(
  parameter int          LINES         = 32,
  parameter int          LINES_PER_GRP = 4,
  parameter int          ADDR_W        = 16,
  parameter int unsigned WIN_BASE      = 'h0C00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [LINES-1:0]  irq_in,
  output logic [LINES-1:0]  irq_out
);
  localparam int GROUPS  = LINES / LINES_PER_GRP;
  localparam int EN_BIT  = 31;
  localparam int IDX_W   = $clog2(GROUPS);
  localparam int WIN_LSB = IDX_W + 3;
  localparam logic [ADDR_W-1:0] WB = ADDR_W'(WIN_BASE);

  function automatic logic [EN_BIT-1:0] init_field(input int i);
    return EN_BIT'((32'h1F << 6) | (i << 2));
  endfunction

  logic [GROUPS-1:0] en_q;
  logic [EN_BIT-1:0] fld_q [GROUPS];
  logic [LINES-1:0]  gated;

  wire              hit    = addr[ADDR_W-1:WIN_LSB] == WB[ADDR_W-1:WIN_LSB];
  wire              upper  = addr[2];
  wire [IDX_W-1:0]  idx    = addr[WIN_LSB-1:3];
  wire              wr_hit = wr_en & hit & upper;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      en_q <= '0;
    else if (!rst_n) en_q <= '0;
    else if (wr_hit) en_q[idx] <= wr_data[EN_BIT];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < GROUPS; i++) fld_q[i] <= init_field(i);
    end else begin
      for (int i = 0; i < GROUPS; i++) fld_q[i] <= fld_q[i];
    end
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign gated[n] = en_q[n / LINES_PER_GRP] & irq_in[n];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      irq_out <= '0;
    else if (!rst_n) irq_out <= '0;
    else             irq_out <= gated;
  end

  assign rd_data = (hit && upper) ? {en_q[idx], fld_q[idx]} : '0;

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    // R8
    dis_grp_low_chk: assert property (@(posedge clk) disable iff (!por_n)
      !en_q[g] |=> irq_out[g*LINES_PER_GRP +: LINES_PER_GRP] == '0);
    // R7
    en_grp_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
      (en_q[g] && rst_n) |=> irq_out[g*LINES_PER_GRP +: LINES_PER_GRP]
                             == $past(irq_in[g*LINES_PER_GRP +: LINES_PER_GRP]));
    // R6
    fld_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> $stable(fld_q[g]));
  end

  // R6
  rst_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> (en_q == '0 && irq_out == '0));
  // R3
  low_wr_ign_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !addr[2] && rst_n) |=> $stable(en_q));
  // R5
  miss_wr_ign_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !hit && rst_n) |=> $stable(en_q));
  // R4
  low_rd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    !addr[2] |-> rd_data == '0);
endmodule

// File: tb/pci_irq_gate_tb.sv
module pci_irq_gate_tb_top;
  logic        clk = 0;
  logic        por_n = 0, rst_n = 1, wr_en = 0;
  logic [15:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data, irq_in = 0, irq_out;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0]  en_m = 0;
  logic [31:0] out_m = 0;

  always #10 clk = ~clk;

  pci_irq_gate dut_i (.clk, .por_n, .rst_n, .wr_en, .addr, .wr_data, .rd_data, .irq_in, .irq_out);

  function automatic logic [31:0] exp_rd(input logic [15:0] a);
    int i;
    if (a[15:6] != 10'(16'h0C00 >> 6) || !a[2]) return 0;
    i = int'(a[5:3]);
    return {en_m[i], 31'((32'h1F << 6) | (i << 2))};
  endfunction

  function automatic logic [31:0] gate(input logic [7:0] en, input logic [31:0] din);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[n] = en[n >> 2] & din[n];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] a, input logic [31:0] d,
                      input logic [31:0] din, input logic r);
    wr_en = w; addr = a; wr_data = d; irq_in = din; rst_n = ~r;
    #1;
    chk((a[15:6] != 10'h030) ? "R5 read" : "R4 read", rd_data, exp_rd(a));
    @(posedge clk);
    out_m = r ? 32'h0 : gate(en_m, din);
    if (r) en_m = 0;
    else if (w && a[15:6] == 10'h030 && a[2]) en_m[a[5:3]] = d[31];
    @(negedge clk);
    chk("R7 R8 out", irq_out, out_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (2) @(negedge clk);
    chk("R1 out", irq_out, 0);
    por_n = 1;
    for (int i = 0; i < 8; i++) begin
      addr = 16'h0C04 | 16'(i << 3); #1;
      chk("R1 por value", rd_data, 32'h7C0 | 32'(i << 2));
    end
    // R3: lower-word write ignored
    step(1, 16'h0C18, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    addr = 16'h0C1C; #1; chk("R3 low write ignored", rd_data, 32'h7CC);
    // R2: upper-word write sets enable only
    step(1, 16'h0C1C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    addr = 16'h0C1C; #1; chk("R2 enable set", rd_data, 32'h8000_07CC);
    // R9: steady inputs, enable takes effect next edge
    step(0, 16'h0C1C, 0, 32'hFFFF_FFFF, 0);
    chk("R9 group3 on", 32'(irq_out[15:12]), 32'hF);
    step(1, 16'h0C1C, 0, 32'hFFFF_FFFF, 0);
    step(0, 16'h0C1C, 0, 32'hFFFF_FFFF, 0);
    chk("R9 group3 off", 32'(irq_out[15:12]), 32'h0);
    // R5: outside window
    step(1, 16'h0C44, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    step(1, 16'h1C0C, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    addr = 16'h0C04; #1; chk("R5 miss write ignored", rd_data, 32'h7C0);
    addr = 16'h0C0C; #1; chk("R5 miss write ignored", rd_data, 32'h7C4);
    // R6: reset wins over same-cycle write, fields kept
    step(1, 16'h0C2C, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    step(1, 16'h0C34, 32'h8000_0000, 32'hFFFF_FFFF, 1);
    chk("R6 out cleared", irq_out, 0);
    addr = 16'h0C2C; #1; chk("R6 enable cleared", rd_data, 32'h7D4);
    addr = 16'h0C34; #1; chk("R6 reset beats write", rd_data, 32'h7D8);
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      a = ($urandom % 4 != 0) ? (16'h0C00 | 16'($urandom % 64)) : 16'($urandom);
      step(1'($urandom % 2), a, $urandom, $urandom, ($urandom % 40) == 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule